// File: doc/BRIEF.md
# Privileged Control and Debug Register Gate

This block sits beside an execution pipeline and carries out privileged moves into and out of a small set of control registers and debug registers. Each request names a direction, a register class (control or debug), a 4-bit index, a 64-bit value to write, an operand size and the old contents of the destination general register. The block checks the request for legality against its own stored control state, the extended-feature long-mode-enable bit and the current long-mode indicator. It then either completes the access or reports one fault class.

A request is taken in one cycle. The block answers in the next cycle with a one-cycle response pulse. The pulse carries a fault code and either a write strobe or a read result merged into the destination at the requested width. The fault checks follow a fixed order, so when several faults apply at once, the one reported is always the same. The block stores the registers itself. What they do to paging, caching or breakpoints is handled elsewhere.

Top module: `privRegGate`

## Requirements
- R1: Every request sampled with `reqValid` high produces exactly one `rspValid` pulse on the next cycle. No pulse appears otherwise. The fault encoding is 0 none, 1 invalid opcode, 2 general protection, 3 debug exception.
- R2: A control-register access, read or write, to index 1, 5, 6, 7 or any index from 9 to 15 reports invalid opcode.
- R3: A write to control index 0 reports general protection in three cases: any of value bits 63:32 is set; bit 31 (paging) is set while bit 0 (protection) is clear; or bit 29 (no-write-through) is set while bit 30 (cache-disable) is clear.
- R4: A write to control index 0 with bit 31 set reports general protection when `eferLme` is high and bit 5 (PAE) of the stored control register 4 is clear.
- R5: A write to control index 4 reports general protection in two cases: any of value bits 63:11 is set, or `longMode` is high and value bit 5 is clear.
- R6: A write to control index 8 with any of bits 63:4 set reports general protection. Writes to control indices 2 and 3 always complete.
- R7: A debug-register access to any index of 8 or above, or to index 4 or 5 while bit 3 (debug extensions) of stored control register 4 is set, reports invalid opcode. This check outranks all other debug checks.
- R8: A write to debug index 6 or 7 with any of bits 63:32 set while `longMode` is high reports general protection. This check outranks R9.
- R9: While bit 13 (general detect) of stored debug register 7 is set, every debug access that passes R7 and R8 reports debug exception.
- R10: A faulting access changes no stored register and leaves `rspWrStrobe` low. Its `rspData` equals the `reqDestOld` that came with the request.
- R11: A legal read returns the selected register merged into `reqDestOld`: `reqOpSize` 0, 1, 2 and 3 replace the low 1, 2, 4 and 8 bytes respectively. A legal write stores all 64 bits, pulses `rspWrStrobe`, and returns `reqDestOld` unchanged.
- R12: After reset every stored register reads as zero and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write to register, 0 = read |
| reqIsDebug | input | 1 | 1 = debug register class, 0 = control |
| reqIndex | input | 4 | Register index |
| reqOpSize | input | 2 | Read merge width: 1, 2, 4, 8 bytes |
| reqWrData | input | 64 | Value to write |
| reqDestOld | input | 64 | Current destination contents |
| eferLme | input | 1 | Long-mode-enable from the extended feature register |
| longMode | input | 1 | Processor is executing in long mode |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 2 | Fault code |
| rspData | output | 64 | Merged read result or unchanged destination |
| rspWrStrobe | output | 1 | A register write was committed |

## Verification
The assertions assume that requests are single-cycle and that every input is known whenever `reqValid` is high. They also assume that `reqOpSize`, `reqWrData` and `reqDestOld` belong to the request sampled in the same cycle. The bench drives one request at a time on the falling edge and returns `reqValid` to low between requests, so the response of each request is never confused with that of a neighbouring one. The fault-ordering properties also rely on the bench: it sets the stored debug-extension and general-detect bits only through legal writes.

// File: rtl/priv_reg_pkg.sv
package priv_reg_pkg;
  parameter int DATA_W  = 64;
  parameter int IDX_W   = 4;
  parameter int NUM_DBG = 8;
  parameter int SIZE_W  = 2;
  parameter int LOW_CUT = 4;  // bits below this go to the checker only through wrBit0

  localparam int BYTES = DATA_W / 8;
  localparam int DBG_W = $clog2(NUM_DBG);

  // bit positions the legality rules depend on
  localparam int CR0_PE = 0;
  localparam int CR0_NW = 29;
  localparam int CR0_CD = 30;
  localparam int CR0_PG = 31;
  localparam int CR4_DE = 3;
  localparam int CR4_PAE = 5;
  localparam int CR4_TOP_OK = 10;
  localparam int DR7_GD = 13;
  localparam int HALF = 32;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2,
    FLT_DB   = 2'd3
  } faultE;

  typedef struct packed {
    logic             wrCtl;
    logic             wrDbg;
    logic             rdOk;
    logic             isDbg;
    logic [IDX_W-1:0] idx;
    logic [SIZE_W-1:0] size;
  } strobeS;
endpackage

// File: rtl/privRegCtrl.sv
module privRegCtrl
  import priv_reg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqIsDebug,
  input  logic [IDX_W-1:0]        reqIndex,
  input  logic [SIZE_W-1:0]       reqOpSize,
  input  logic [DATA_W-1:LOW_CUT] wrUpper,
  input  logic                    wrBit0,
  input  logic                    eferLme,
  input  logic                    longMode,
  input  logic                    cr4Pae,
  input  logic                    cr4De,
  input  logic                    dr7Gd,
  output strobeS                  strb,
  output logic                    rspValid,
  output faultE                   rspFault,
  output logic                    rspWrStrobe
);
  faultE faultNow;
  logic  ctlIdxOk;
  logic  dbgAlias;
  logic  dbgHighIdx;
  logic  hiHalfSet;

  assign ctlIdxOk   = (reqIndex == 4'd0) || (reqIndex == 4'd2) || (reqIndex == 4'd3) ||
                      (reqIndex == 4'd4) || (reqIndex == 4'd8);
  assign dbgAlias   = (reqIndex == 4'd4) || (reqIndex == 4'd5);
  assign dbgHighIdx = (reqIndex >= IDX_W'(NUM_DBG));
  assign hiHalfSet  = |wrUpper[DATA_W-1:HALF];

  always_comb begin
    faultNow = FLT_NONE;
    if (!reqIsDebug) begin
      if (!ctlIdxOk) begin
        faultNow = FLT_UD;
      end else if (reqWrite) begin
        unique case (reqIndex)
          4'd0: begin
            if (hiHalfSet ||
                (wrUpper[CR0_PG] && !wrBit0) ||
                (wrUpper[CR0_NW] && !wrUpper[CR0_CD]) ||
                (wrUpper[CR0_PG] && eferLme && !cr4Pae))
              faultNow = FLT_GP;
          end
          4'd4: begin
            if ((|wrUpper[DATA_W-1:CR4_TOP_OK+1]) || (longMode && !wrUpper[CR4_PAE]))
              faultNow = FLT_GP;
          end
          4'd8: begin
            if (|wrUpper)
              faultNow = FLT_GP;
          end
          default: faultNow = FLT_NONE;
        endcase
      end
    end else begin
      if (dbgHighIdx || (cr4De && dbgAlias)) begin
        faultNow = FLT_UD;
      end else if (reqWrite && (reqIndex == 4'd6 || reqIndex == 4'd7) && longMode && hiHalfSet) begin
        faultNow = FLT_GP;
      end else if (dr7Gd) begin
        faultNow = FLT_DB;
      end
    end
  end

  always_comb begin
    strb.wrCtl = reqValid && reqWrite && !reqIsDebug && (faultNow == FLT_NONE);
    strb.wrDbg = reqValid && reqWrite && reqIsDebug && (faultNow == FLT_NONE);
    strb.rdOk  = reqValid && !reqWrite && (faultNow == FLT_NONE);
    strb.isDbg = reqIsDebug;
    strb.idx   = reqIndex;
    strb.size  = reqOpSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspFault    <= FLT_NONE;
      rspWrStrobe <= 1'b0;
    end else begin
      rspValid    <= reqValid;
      rspFault    <= reqValid ? faultNow : FLT_NONE;
      rspWrStrobe <= strb.wrCtl || strb.wrDbg;
    end
  end
endmodule

// File: rtl/privRegData.sv
module privRegData
  import priv_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strb,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] reqDestOld,
  output logic              cr4Pae,
  output logic              cr4De,
  output logic              dr7Gd,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] ctl0, ctl2, ctl3, ctl4, ctl8;
  logic [DATA_W-1:0] dbgReg [NUM_DBG];
  logic [DATA_W-1:0] selVal;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl0 <= '0;
      ctl2 <= '0;
      ctl3 <= '0;
      ctl4 <= '0;
      ctl8 <= '0;
    end else if (strb.wrCtl) begin
      unique case (strb.idx)
        4'd0: ctl0 <= reqWrData;
        4'd2: ctl2 <= reqWrData;
        4'd3: ctl3 <= reqWrData;
        4'd4: ctl4 <= reqWrData;
        4'd8: ctl8 <= reqWrData;
        default: ;
      endcase
    end
  end

  for (genvar d = 0; d < NUM_DBG; d++) begin : g_dbg
    always_ff @(posedge clk) begin
      if (!rstN)
        dbgReg[d] <= '0;
      else if (strb.wrDbg && (strb.idx[DBG_W-1:0] == DBG_W'(d)))
        dbgReg[d] <= reqWrData;
    end
  end

  assign cr4Pae = ctl4[CR4_PAE];
  assign cr4De  = ctl4[CR4_DE];
  assign dr7Gd  = dbgReg[7][DR7_GD];

  always_comb begin
    if (strb.isDbg) begin
      selVal = dbgReg[strb.idx[DBG_W-1:0]];
    end else begin
      unique case (strb.idx)
        4'd0:    selVal = ctl0;
        4'd2:    selVal = ctl2;
        4'd3:    selVal = ctl3;
        4'd4:    selVal = ctl4;
        4'd8:    selVal = ctl8;
        default: selVal = '0;
      endcase
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    logic takeByte;
    assign takeByte = (b < (1 << strb.size));
    assign merged[b*8 +: 8] = takeByte ? selVal[b*8 +: 8] : reqDestOld[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rspData <= '0;
    else
      rspData <= strb.rdOk ? merged : reqDestOld;
  end
endmodule

// File: rtl/privRegGate.sv
module privRegGate
  import priv_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqIsDebug,
  input  logic [3:0]  reqIndex,
  input  logic [1:0]  reqOpSize,
  input  logic [63:0] reqWrData,
  input  logic [63:0] reqDestOld,
  input  logic        eferLme,
  input  logic        longMode,
  output logic        rspValid,
  output logic [1:0]  rspFault,
  output logic [63:0] rspData,
  output logic        rspWrStrobe
);
  strobeS strb;
  faultE  faultQ;
  logic   cr4Pae, cr4De, dr7Gd;

  privRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqIsDebug(reqIsDebug),
    .reqIndex(reqIndex), .reqOpSize(reqOpSize),
    .wrUpper(reqWrData[DATA_W-1:LOW_CUT]), .wrBit0(reqWrData[0]),
    .eferLme(eferLme), .longMode(longMode),
    .cr4Pae(cr4Pae), .cr4De(cr4De), .dr7Gd(dr7Gd),
    .strb(strb), .rspValid(rspValid), .rspFault(faultQ), .rspWrStrobe(rspWrStrobe)
  );

  privRegData u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrData(reqWrData), .reqDestOld(reqDestOld),
    .cr4Pae(cr4Pae), .cr4De(cr4De), .dr7Gd(dr7Gd),
    .rspData(rspData)
  );

  assign rspFault = faultQ;
endmodule

// File: rtl/privRegGateChk.sv
module privRegGateChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        reqIsDebug,
  input logic [3:0]  reqIndex,
  input logic [63:0] reqWrData,
  input logic [63:0] reqDestOld,
  input logic        longMode,
  input logic        rspValid,
  input logic [1:0]  rspFault,
  input logic [63:0] rspData,
  input logic        rspWrStrobe
);
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    rspWrStrobe |-> (rspValid && rspFault == 2'd0));

  a_r10_fault_keeps_dest: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspData == $past(reqDestOld)));

  a_r8_gp_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd2) |-> $past(reqWrite));

  a_r2_bad_index: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIndex > 4'd8) |=> (rspFault == 2'd1));

  a_r6_free_regs: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqIsDebug && (reqIndex == 4'd2 || reqIndex == 4'd3)) |=> rspWrStrobe);

  a_r5_keep_pae: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqIsDebug && reqIndex == 4'd4 && longMode && !reqWrData[5])
      |=> (rspFault == 2'd2));
endmodule

bind privRegGate privRegGateChk u_chk (.*);

// File: tb/privRegGate_bench.sv
module privRegGate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIsDebug = 1'b0;
  logic [3:0]  reqIndex = '0;
  logic [1:0]  reqOpSize = '0;
  logic [63:0] reqWrData = '0, reqDestOld = '0;
  logic        eferLme = 1'b0, longMode = 1'b0;
  logic        rspValid, rspWrStrobe;
  logic [1:0]  rspFault;
  logic [63:0] rspData;

  int total = 0;
  int bad = 0;
  logic [63:0] ctlM [16];
  logic [63:0] dbgM [8];

  always #2 clk = ~clk;

  privRegGate u_privRegGate (.*);

  function automatic int refFault(bit wr, bit dbg, int idx, logic [63:0] v, bit lme, bit lm);
    if (!dbg) begin
      if (!(idx == 0 || idx == 2 || idx == 3 || idx == 4 || idx == 8)) return 1;
      if (!wr) return 0;
      if (idx == 0) begin
        if (v[63:32] != 0) return 2;
        if (v[31] && !v[0]) return 2;
        if (v[29] && !v[30]) return 2;
        if (v[31] && lme && !ctlM[4][5]) return 2;
      end
      if (idx == 4 && (v[63:11] != 0 || (lm && !v[5]))) return 2;
      if (idx == 8 && v[63:4] != 0) return 2;
      return 0;
    end
    if (idx >= 8 || (ctlM[4][3] && (idx == 4 || idx == 5))) return 1;
    if (wr && (idx == 6 || idx == 7) && lm && v[63:32] != 0) return 2;
    if (dbgM[7][13]) return 3;
    return 0;
  endfunction

  task automatic check(string req, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(string req, bit wr, bit dbg, int idx, logic [63:0] v, int sz,
                        logic [63:0] dest, bit lme, bit lm);
    int ef;
    logic [63:0] expD;
    logic [63:0] src;
    ef = refFault(wr, dbg, idx, v, lme, lm);
    expD = dest;
    if (ef == 0 && !wr) begin
      src = dbg ? dbgM[idx] : ctlM[idx];
      for (int b = 0; b < (1 << sz); b++) expD[b*8 +: 8] = src[b*8 +: 8];
    end
    reqValid = 1'b1; reqWrite = wr; reqIsDebug = dbg; reqIndex = 4'(idx);
    reqWrData = v; reqOpSize = 2'(sz); reqDestOld = dest; eferLme = lme; longMode = lm;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(req, rspValid == 1'b1, "valid", 64'(rspValid), 64'd1);
    check(req, rspFault == 2'(ef), "fault", 64'(rspFault), 64'(ef));
    check(req, rspData == expD, "data", rspData, expD);
    check(req, rspWrStrobe == (wr && ef == 0), "strobe", 64'(rspWrStrobe), 64'(wr && ef == 0));
    if (ef == 0 && wr) begin
      if (dbg) dbgM[idx] = v; else ctlM[idx] = v;
    end
    @(posedge clk);
    @(negedge clk);
    check("R1", rspValid == 1'b0, "idle", 64'(rspValid), 64'd0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ctlM[i] = '0;
    for (int i = 0; i < 8; i++) dbgM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", rspValid == 1'b0, "reset valid", 64'(rspValid), 64'd0);
    access("R12", 0, 0, 0, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    access("R12", 0, 1, 7, 0, 3, 64'h1234, 0, 0);
    // R2: illegal control indices
    access("R2", 0, 0, 1, 0, 3, 64'hAA, 0, 0);
    access("R2", 1, 0, 5, 64'h1, 3, 64'hBB, 0, 0);
    access("R2", 1, 0, 7, 64'h1, 3, 64'hBB, 0, 0);
    access("R2", 0, 0, 9, 0, 3, 64'hCC, 0, 0);
    access("R2", 1, 0, 15, 64'h5, 3, 64'hDD, 0, 0);
    // R6: free registers and control 8
    access("R6", 1, 0, 2, 64'hDEAD_BEEF_0123_4567, 3, 64'h0, 0, 0);
    access("R6", 1, 0, 3, 64'hFFFF_0000_FFFF_0000, 3, 64'h0, 0, 0);
    access("R6", 1, 0, 8, 64'hF, 3, 64'h0, 0, 0);
    access("R6", 1, 0, 8, 64'h10, 3, 64'h0, 0, 0);
    access("R10", 0, 0, 8, 0, 3, 64'h0, 0, 0);
    // R3: control 0 combinations
    access("R3", 1, 0, 0, 64'h1_0000_0000, 3, 64'h7, 0, 0);
    access("R3", 1, 0, 0, 64'h8000_0000, 3, 64'h7, 0, 0);
    access("R3", 1, 0, 0, 64'h2000_0000, 3, 64'h7, 0, 0);
    access("R3", 1, 0, 0, 64'h6000_0011, 3, 64'h7, 0, 0);
    access("R3", 0, 0, 0, 0, 3, 64'h0, 0, 0);
    // R5: control 4
    access("R5", 1, 0, 4, 64'h800, 3, 64'h0, 0, 0);
    access("R5", 1, 0, 4, 64'h0, 3, 64'h0, 0, 1);
    access("R5", 1, 0, 4, 64'h0, 3, 64'h0, 0, 0);
    // R4: paging with long-mode enable and PAE clear
    access("R4", 1, 0, 0, 64'h8000_0001, 3, 64'h0, 1, 0);
    access("R4", 1, 0, 0, 64'h8000_0001, 3, 64'h0, 0, 0);
    access("R5", 1, 0, 4, 64'h20, 3, 64'h0, 0, 1);
    access("R4", 1, 0, 0, 64'h8000_0011, 3, 64'h0, 1, 1);
    access("R4", 0, 0, 0, 0, 3, 64'h0, 1, 1);
    // R11: merge widths
    access("R11", 0, 0, 2, 0, 0, 64'h1111_2222_3333_4444, 0, 0);
    access("R11", 0, 0, 2, 0, 1, 64'h1111_2222_3333_4444, 0, 0);
    access("R11", 0, 0, 2, 0, 2, 64'h1111_2222_3333_4444, 0, 0);
    access("R11", 0, 0, 2, 0, 3, 64'h1111_2222_3333_4444, 0, 0);
    // R7: debug index rules
    access("R7", 0, 1, 8, 0, 3, 64'h9, 0, 0);
    access("R7", 1, 1, 4, 64'h44, 3, 64'h0, 0, 0);
    access("R7", 0, 1, 4, 0, 3, 64'h0, 0, 0);
    access("R7", 1, 0, 4, 64'h28, 3, 64'h0, 0, 0);
    access("R7", 0, 1, 4, 0, 3, 64'h0, 0, 0);
    access("R7", 1, 1, 5, 64'h55, 3, 64'h0, 0, 0);
    access("R7", 1, 0, 4, 64'h20, 3, 64'h0, 0, 0);
    access("R7", 1, 1, 5, 64'h55, 3, 64'h0, 0, 0);
    access("R7", 0, 1, 5, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    // R8: high half of debug 6/7 in long mode
    access("R8", 1, 1, 6, 64'h1_0000_0000, 3, 64'h0, 0, 1);
    access("R8", 1, 1, 7, 64'h2_0000_0000, 3, 64'h0, 0, 1);
    access("R8", 1, 1, 6, 64'h1_0000_0000, 3, 64'h0, 0, 0);
    access("R8", 1, 1, 0, 64'hFFFF_0000_0000_0001, 3, 64'h0, 0, 1);
    access("R8", 0, 1, 6, 0, 3, 64'h0, 0, 0);
    // R9: general detect
    access("R9", 1, 1, 7, 64'h2000, 3, 64'h0, 0, 0);
    access("R9", 0, 1, 0, 0, 3, 64'h77, 0, 0);
    access("R9", 1, 1, 1, 64'h3, 3, 64'h77, 0, 0);
    access("R8", 1, 1, 7, 64'h1_0000_0000, 3, 64'h0, 0, 1);
    access("R7", 0, 1, 12, 0, 3, 64'h0, 0, 0);
    access("R9", 1, 0, 4, 64'h28, 3, 64'h0, 0, 0);
    access("R7", 0, 1, 4, 0, 3, 64'h0, 0, 0);
    access("R9", 0, 0, 2, 0, 3, 64'h0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule